// File: doc/BRIEF.md
# Hybrid Circuit/Packet Router Output Stage

This block is the switching core of one mesh router. Circuit-switched and packet-switched flits share the same output links. A flit that carries the circuit tag and names a plane that holds a valid route entry for its input port skips buffering and allocation. It crosses the crossbar in a single register stage and reaches the output that the entry names. Every other flit is written into a small per-input FIFO. It then competes for its destination output in a round-robin allocator and is switched one stage later. Packet flits therefore see three register stages from input to link.

A packet flit takes a link only in a cycle when no circuit flit claims that link. In this way packet traffic fills the idle cycles of reserved circuits. A neighbouring setup block writes the route table one entry at a time, giving an input port, a plane, a valid bit and an output port. A circuit flit whose entry is not valid is demoted to the packet path and is routed by its own destination field. Flow control toward the next router is reduced to one ready bit per output. The ready bit holds back packet flits only.

Top module: `hcs_router`

## Requirements
- R1: In reset and in the first cycle after it, every out_valid bit is 0 and every in_ready bit is 1.
- R2: A flit with in_circ=1 whose plane has a valid entry for its input leaves on that entry's output one clock edge after it is presented. It keeps out_circ=1 along with its plane and data. No copy of it is buffered or sent later.
- R3: A packet flit (in_circ=0) to an idle output leaves on the output given by its destination field three clock edges after it is presented, with out_circ=0.
- R4: A circuit flit claims its output with priority. A packet flit that is waiting for that output leaves in the first cycle in which no circuit flit claims it.
- R5: A flit with in_circ=1 whose plane entry is not valid is buffered as a packet flit. It leaves by its destination field three edges later, with out_circ=0 and its plane field kept.
- R6: Packet flits from several inputs that compete for one output are granted in rotating order, starting after the last input granted. After reset the search starts at input 0.
- R7: Each input buffer holds FIFO_DEPTH flits. in_ready drops only after a flit is accepted into a buffer that then becomes full. Flits leave in arrival order.
- R8: While out_ready of an output is 0, no packet flit leaves on it, but circuit flits still do.
- R9: If two matched circuit flits claim the same output in one cycle, the lower-numbered input wins and the other flit is demoted to the packet path.
- R10: A route table write takes effect for flits presented in the following cycle. Writing valid=0 demotes later flits on that plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Flit present, per input port |
| in_circ | input | 4 | Circuit tag bit, per input |
| in_plane | input | 8 | Plane id, 2 bits per input |
| in_dest | input | 8 | Packet destination output, 2 bits per input |
| in_data | input | 64 | Payload, 16 bits per input |
| in_ready | output | 4 | Input buffer can accept a flit |
| cfg_we | input | 1 | Route table write strobe |
| cfg_port | input | 2 | Input port of the entry written |
| cfg_plane | input | 2 | Plane of the entry written |
| cfg_valid | input | 1 | Valid bit written |
| cfg_out | input | 2 | Output port written |
| out_ready | input | 4 | Downstream can take a packet flit, per output |
| out_valid | output | 4 | Flit on the link, per output |
| out_circ | output | 4 | Flit travels as circuit flit |
| out_plane | output | 8 | Plane id, 2 bits per output |
| out_dest | output | 8 | Destination field, 2 bits per output |
| out_data | output | 64 | Payload, 16 bits per output |

## Verification
The assertions check four things on every cycle: that the outputs are idle after reset, that no packet flit leaves an output whose ready was low, that circuit flits on the links never outnumber the tagged flits offered one cycle earlier, and that an input's ready falls only after that input offers a flit. The directed scenarios cover the behaviours that depend on exact timing and content. These are the one-edge versus three-edge latency, the use of idle circuit cycles by packet flits, demotion on a missing or cleared entry, the lower-input rule for colliding circuits, the rotating grant order and FIFO ordering under back-pressure.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    localparam int HCS_PORTS   = 4;
    localparam int HCS_PLANES  = 4;
    localparam int HCS_DATA_W  = 16;
    localparam int HCS_PORT_W  = $clog2(HCS_PORTS);
    localparam int HCS_PLANE_W = $clog2(HCS_PLANES);

    typedef logic [HCS_PORT_W-1:0]  port_id_t;
    typedef logic [HCS_PLANE_W-1:0] plane_id_t;

    typedef struct packed {
        logic                  circ;
        plane_id_t             plane;
        port_id_t              dest;
        logic [HCS_DATA_W-1:0] data;
    } flit_t;

    typedef struct packed {
        logic     vld;
        port_id_t outp;
    } route_t;

    // A flit entering a buffer travels from then on as a packet flit.
    function automatic flit_t as_packet(flit_t f);
        flit_t r;
        r      = f;
        r.circ = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/hcs_fifo.sv
module hcs_fifo
    import hcs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  flit_t din,
    input  logic  pop,
    output flit_t dout,
    output logic  full,
    output logic  empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    flit_t          mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hcs_rr_arb.sv
module hcs_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic [IW-1:0] idx;
    logic [N-1:0]  pick;
    logic          found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        win   = '0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            idx = IW'((int'(ptr) + k) % N);
            if (!found && req[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
                win       = idx;
            end
        end
    end

    assign gnt = en ? pick : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (en && found) begin
            ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
        end
    end

endmodule

// File: rtl/hcs_router.sv
module hcs_router
    import hcs_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [HCS_PORTS-1:0]            in_valid,
    input  logic [HCS_PORTS-1:0]            in_circ,
    input  logic [HCS_PORTS*HCS_PLANE_W-1:0] in_plane,
    input  logic [HCS_PORTS*HCS_PORT_W-1:0] in_dest,
    input  logic [HCS_PORTS*HCS_DATA_W-1:0] in_data,
    output logic [HCS_PORTS-1:0]            in_ready,
    input  logic                            cfg_we,
    input  logic [HCS_PORT_W-1:0]           cfg_port,
    input  logic [HCS_PLANE_W-1:0]          cfg_plane,
    input  logic                            cfg_valid,
    input  logic [HCS_PORT_W-1:0]           cfg_out,
    input  logic [HCS_PORTS-1:0]            out_ready,
    output logic [HCS_PORTS-1:0]            out_valid,
    output logic [HCS_PORTS-1:0]            out_circ,
    output logic [HCS_PORTS*HCS_PLANE_W-1:0] out_plane,
    output logic [HCS_PORTS*HCS_PORT_W-1:0] out_dest,
    output logic [HCS_PORTS*HCS_DATA_W-1:0] out_data
);
    localparam int NP  = HCS_PORTS;
    localparam int NPL = HCS_PLANES;
    localparam int PW  = HCS_PORT_W;
    localparam int LW  = HCS_PLANE_W;
    localparam int DW  = HCS_DATA_W;

    flit_t          in_flit   [NP];
    route_t         route_of  [NP];
    route_t         tbl       [NP][NPL];
    logic [NP-1:0]  hit;
    logic [NP-1:0]  circ_win;
    logic [NP-1:0]  claim;
    flit_t          claim_flit[NP];
    logic [NP-1:0]  push, pop, full, empty;
    flit_t          head      [NP];
    logic [NP-1:0]  req       [NP];
    logic [NP-1:0]  gnt       [NP];
    flit_t          st_in     [NP];
    logic [NP-1:0]  st_free;

    // Route table written by the setup block
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NP; i++)
                for (int p = 0; p < NPL; p++)
                    tbl[i][p] <= '0;
        end else if (cfg_we) begin
            tbl[cfg_port][cfg_plane] <= '{vld: cfg_valid, outp: cfg_out};
        end
    end

    // Input unpacking, route lookup and buffers
    for (genvar i = 0; i < NP; i++) begin : g_in
        assign in_flit[i]  = '{circ:  in_circ[i],
                              plane: in_plane[i*LW +: LW],
                              dest:  in_dest[i*PW +: PW],
                              data:  in_data[i*DW +: DW]};
        assign route_of[i] = tbl[i][in_flit[i].plane];
        assign hit[i]      = in_valid[i] && in_flit[i].circ && route_of[i].vld;
        assign push[i]     = in_valid[i] && !circ_win[i];
        assign in_ready[i] = !full[i];

        hcs_fifo #(.DEPTH(FIFO_DEPTH)) u_buf (
            .clk   (clk),
            .rst   (rst),
            .push  (push[i]),
            .din   (as_packet(in_flit[i])),
            .pop   (pop[i]),
            .dout  (head[i]),
            .full  (full[i]),
            .empty (empty[i])
        );
    end

    // Circuit claims: lowest input wins a contested output, losers are buffered
    always_comb begin
        claim    = '0;
        circ_win = '0;
        for (int o = 0; o < NP; o++) claim_flit[o] = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                if (hit[i] && route_of[i].outp == PW'(o) && !claim[o]) begin
                    claim[o]      = 1'b1;
                    circ_win[i]   = 1'b1;
                    claim_flit[o] = in_flit[i];
                end
            end
        end
    end

    // Switch allocation: pop the granted buffer heads
    always_comb begin
        pop = '0;
        for (int o = 0; o < NP; o++) begin
            st_in[o] = '0;
            for (int i = 0; i < NP; i++) begin
                if (gnt[o][i]) begin
                    pop[i]   = 1'b1;
                    st_in[o] = head[i];
                end
            end
        end
    end

    // Per-output arbiter, traversal register and link register
    for (genvar o = 0; o < NP; o++) begin : g_out
        logic  st_vld;
        flit_t st_flit;
        logic  st_go;
        logic  lk_vld;
        flit_t lk_flit;

        for (genvar i = 0; i < NP; i++) begin : g_req
            assign req[o][i] = !empty[i] && (head[i].dest == PW'(o));
        end

        assign st_go      = st_vld && out_ready[o] && !claim[o];
        assign st_free[o] = !st_vld || st_go;

        hcs_rr_arb #(.N(NP)) u_arb (
            .clk (clk),
            .rst (rst),
            .en  (st_free[o]),
            .req (req[o]),
            .gnt (gnt[o])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                st_vld  <= 1'b0;
                st_flit <= '0;
                lk_vld  <= 1'b0;
                lk_flit <= '0;
            end else begin
                if (|gnt[o]) begin
                    st_vld  <= 1'b1;
                    st_flit <= st_in[o];
                end else if (st_go) begin
                    st_vld  <= 1'b0;
                end

                if (claim[o]) begin
                    lk_vld  <= 1'b1;
                    lk_flit <= claim_flit[o];
                end else if (st_go) begin
                    lk_vld  <= 1'b1;
                    lk_flit <= st_flit;
                end else begin
                    lk_vld  <= 1'b0;
                end
            end
        end

        assign out_valid[o]           = lk_vld;
        assign out_circ[o]            = lk_flit.circ;
        assign out_plane[o*LW +: LW]  = lk_flit.plane;
        assign out_dest[o*PW +: PW]   = lk_flit.dest;
        assign out_data[o*DW +: DW]   = lk_flit.data;
    end

endmodule

// File: rtl/hcs_router_chk.sv
module hcs_router_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] in_valid,
    input logic [N-1:0] in_circ,
    input logic [N-1:0] in_ready,
    input logic [N-1:0] out_ready,
    input logic [N-1:0] out_valid,
    input logic [N-1:0] out_circ
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0 && in_ready == '1));

    // R2
    circ_source_chk: assert property (@(posedge clk) disable iff (rst)
        ((out_valid & out_circ) != '0) |-> $past((in_valid & in_circ) != '0));

    // R9
    circ_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(out_valid & out_circ) <= $past($countones(in_valid & in_circ)));

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R8
        ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !out_ready[k] |=> !(out_valid[k] && !out_circ[k]));

        // R7
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(in_ready[k]) |-> $past(in_valid[k]));
    end

endmodule

bind hcs_router hcs_router_chk #(.N(hcs_pkg::HCS_PORTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_circ   (in_circ),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_circ  (out_circ)
);

// File: tb/hcs_router_tb.sv
`timescale 1ns/1ps
module hcs_router_tb_top;
    import hcs_pkg::*;

    localparam int NP = HCS_PORTS;
    localparam int PW = HCS_PORT_W;
    localparam int LW = HCS_PLANE_W;
    localparam int DW = HCS_DATA_W;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [NP-1:0]        in_valid, in_circ, in_ready, out_ready;
    logic [NP*LW-1:0]     in_plane, out_plane;
    logic [NP*PW-1:0]     in_dest, out_dest;
    logic [NP*DW-1:0]     in_data, out_data;
    logic                 cfg_we, cfg_valid;
    logic [PW-1:0]        cfg_port, cfg_out;
    logic [LW-1:0]        cfg_plane;
    logic [NP-1:0]        out_valid, out_circ;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    hcs_router dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_circ(in_circ), .in_plane(in_plane),
        .in_dest(in_dest), .in_data(in_data), .in_ready(in_ready),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_plane(cfg_plane),
        .cfg_valid(cfg_valid), .cfg_out(cfg_out),
        .out_ready(out_ready), .out_valid(out_valid), .out_circ(out_circ),
        .out_plane(out_plane), .out_dest(out_dest), .out_data(out_data)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] odata(int o);
        return out_data[o*DW +: DW];
    endfunction

    function automatic logic [LW-1:0] oplane(int o);
        return out_plane[o*LW +: LW];
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        in_valid = '0; in_circ = '0; in_plane = '0; in_dest = '0; in_data = '0;
    endtask

    task automatic send(int i, bit circ, int plane, int dest, int data);
        in_valid[i]          = 1'b1;
        in_circ[i]           = circ;
        in_plane[i*LW +: LW] = LW'(plane);
        in_dest[i*PW +: PW]  = PW'(dest);
        in_data[i*DW +: DW]  = DW'(data);
    endtask

    task automatic do_reset();
        rst = 1'b1; clear_in(); cfg_we = 1'b0; cfg_valid = 1'b0;
        cfg_port = '0; cfg_plane = '0; cfg_out = '0; out_ready = '1;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic cfg_write(int port, int plane, bit vld, int outp);
        cfg_we = 1'b1; cfg_port = PW'(port); cfg_plane = LW'(plane);
        cfg_valid = vld; cfg_out = PW'(outp);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "out_valid after reset", 32'(out_valid), 32'h0);
        check("R1", "in_ready after reset", 32'(in_ready), 32'hF);
    endtask

    task automatic t_circuit();
        do_reset();
        cfg_write(0, 1, 1, 2);
        send(0, 1, 1, 0, 16'hC001);
        step(); clear_in();
        check("R2", "circuit out_valid", 32'(out_valid), 32'h4);
        check("R2", "circuit tag kept", 32'(out_circ[2]), 32'h1);
        check("R2", "circuit plane kept", 32'(oplane(2)), 32'h1);
        check("R10", "new entry used, data", 32'(odata(2)), 32'hC001);
        step(); step();
        check("R2", "no buffered copy", 32'(out_valid), 32'h0);
        step();
        check("R2", "no buffered copy later", 32'(out_valid), 32'h0);
    endtask

    task automatic t_packet();
        do_reset();
        send(1, 0, 0, 3, 16'h00A1);
        step(); clear_in();
        check("R3", "idle after 1 edge", 32'(out_valid), 32'h0);
        step();
        check("R3", "idle after 2 edges", 32'(out_valid), 32'h0);
        step();
        check("R3", "packet out_valid", 32'(out_valid), 32'h8);
        check("R3", "packet tag", 32'(out_circ[3]), 32'h0);
        check("R3", "packet data", 32'(odata(3)), 32'h00A1);
    endtask

    task automatic t_steal();
        do_reset();
        cfg_write(0, 0, 1, 1);
        send(2, 0, 0, 1, 16'h00B2);
        step(); clear_in();
        step();
        send(0, 1, 0, 0, 16'hC100);
        step();
        check("R4", "circuit wins cycle 1", 32'(odata(1)), 32'hC100);
        check("R4", "circuit tag cycle 1", 32'(out_circ[1]), 32'h1);
        clear_in(); send(0, 1, 0, 0, 16'hC101);
        step(); clear_in();
        check("R4", "circuit wins cycle 2", 32'(odata(1)), 32'hC101);
        step();
        check("R4", "packet steals idle cycle", {15'h0, out_valid[1], out_circ[1], odata(1)},
              {15'h0, 1'b1, 1'b0, 16'h00B2});
    endtask

    task automatic t_demote();
        do_reset();
        send(3, 1, 2, 0, 16'h00D5);
        step(); clear_in();
        check("R5", "no fast path without entry", 32'(out_valid), 32'h0);
        step(); step();
        check("R5", "demoted out_valid", 32'(out_valid), 32'h1);
        check("R5", "demoted tag cleared", 32'(out_circ[0]), 32'h0);
        check("R5", "demoted plane kept", 32'(oplane(0)), 32'h2);
        check("R5", "demoted data", 32'(odata(0)), 32'h00D5);
    endtask

    task automatic t_rr();
        do_reset();
        send(1, 0, 0, 3, 16'h0A0A);
        send(2, 0, 0, 3, 16'h0C0C);
        step(); clear_in();
        send(1, 0, 0, 3, 16'h0B0B);
        step(); clear_in();
        step();
        check("R6", "first grant input 1", 32'(odata(3)), 32'h0A0A);
        step();
        check("R6", "rotates to input 2", 32'(odata(3)), 32'h0C0C);
        step();
        check("R6", "back to input 1", 32'(odata(3)), 32'h0B0B);
    endtask

    task automatic t_full();
        do_reset();
        out_ready = 4'b1110;
        for (int k = 0; k < 5; k++) begin
            send(1, 0, 0, 0, 16'hE000 + k);
            step();
            if (k == 3) check("R7", "ready with room left", 32'(in_ready[1]), 32'h1);
        end
        clear_in();
        check("R7", "ready low when full", 32'(in_ready[1]), 32'h0);
        check("R8", "no packet while not ready", 32'(out_valid[0]), 32'h0);
        out_ready = '1;
        step();
        check("R7", "first out in order", 32'(odata(0)), 32'hE000);
        check("R7", "ready back after drain", 32'(in_ready[1]), 32'h1);
        for (int k = 1; k < 5; k++) begin
            step();
            check("R7", "fifo order", {15'h0, out_valid[0], odata(0)}, {15'h0, 1'b1, 16'hE000 + 16'(k)});
        end
    endtask

    task automatic t_ready_circ();
        do_reset();
        cfg_write(0, 1, 1, 2);
        out_ready = 4'b1011;
        send(0, 1, 1, 0, 16'hC0DE);
        step(); clear_in();
        check("R8", "circuit ignores ready", {15'h0, out_valid[2], odata(2)}, {15'h0, 1'b1, 16'hC0DE});
        out_ready = '1;
    endtask

    task automatic t_conflict();
        do_reset();
        cfg_write(0, 1, 1, 2);
        cfg_write(1, 3, 1, 2);
        send(0, 1, 1, 0, 16'h00F0);
        send(1, 1, 3, 1, 16'h00F1);
        step(); clear_in();
        check("R9", "single winner valid", 32'(out_valid), 32'h4);
        check("R9", "lower input wins", 32'(odata(2)), 32'h00F0);
        step(); step();
        check("R9", "loser demoted to dest", {14'h0, out_valid[1], out_circ[1], odata(1)},
              {14'h0, 1'b1, 1'b0, 16'h00F1});
    endtask

    task automatic t_clear();
        do_reset();
        cfg_write(0, 1, 1, 2);
        cfg_write(0, 1, 0, 2);
        send(0, 1, 1, 3, 16'h009A);
        step(); clear_in();
        check("R10", "cleared entry not used", 32'(out_valid), 32'h0);
        step(); step();
        check("R10", "cleared plane demotes", {14'h0, out_valid[3], out_circ[3], odata(3)},
              {14'h0, 1'b1, 1'b0, 16'h009A});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: all requirements, actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_circuit();
        t_packet();
        t_steal();
        t_demote();
        t_rr();
        t_full();
        t_ready_circ();
        t_conflict();
        t_clear();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule